// File: doc/BRIEF.md
# Transmit Power Sample Averager

This block condenses one word of packed transmit-power sensor readings into a single power estimate. The word carries four unsigned sample lanes, and a side flag says whether the readings came from OFDM or CCK frames. The block screens every lane for a reading stuck at either rail. For OFDM it folds each reading into a 6-bit range with a fixed offset. It then forms the mean with a half-step round-up. When OFDM boost is enabled, it removes a fixed boost correction that is clamped at zero.

One cycle after the input strobe, the result appears together with a one-cycle done pulse and an error flag. The result is a zero average plus the error flag, or a usable average. A usable result also produces a one-cycle clear request, which carries a refill word holding the rail code in every lane. Surrounding logic can write that word back to the sample store to mark the readings as consumed.

Top module: `txpwr_sample_avg`

## Requirements
- R1: The input word is split into lanes of 8 bits, lane 0 in bits 7:0 up to lane 3 in bits 31:24. If any raw lane equals 0 or the rail code (default 0x7F), `out_err` is 1 for that result, and this holds in either mode.
- R2: A result with no rail lane raises `out_clr_req` for exactly the done cycle, with `out_clr_word` equal to the rail code in all four lanes (0x7F7F7F7F by default). An error result leaves `out_clr_req` at 0 and `out_clr_word` at 0.
- R3: In CCK mode (`in_ofdm`=0), `out_avg` equals (a+b+c+d+2)/4 with truncating division.
- R4: In OFDM mode (`in_ofdm`=1), each lane is first replaced by the low 6 bits of (lane+32), and the mean of R3 is then formed from these values.
- R5: In OFDM mode with `in_boost_en`=1, 13 is subtracted from the mean. A mean below 13 gives 0, and a mean of exactly 13 also gives 0.
- R6: In CCK mode, `in_boost_en` has no effect on `out_avg`.
- R7: `out_done` is 1 in the cycle after each cycle with `in_valid`=1, and 0 after every cycle with `in_valid`=0. Strobes in back-to-back cycles each produce their own result.
- R8: After reset, `out_done`, `out_err`, `out_clr_req`, `out_avg` and `out_clr_word` are all 0.
- R9: An error result drives `out_avg` to 0.
- R10: `out_avg` and `out_err` hold their last result while `in_valid` is 0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample word strobe |
| in_word | input | 32 | Four packed sensor samples |
| in_ofdm | input | 1 | 1: OFDM samples, 0: CCK samples |
| in_boost_en | input | 1 | Enables the boost correction in OFDM mode |
| out_done | output | 1 | One-cycle result pulse |
| out_avg | output | 8 | Averaged power estimate |
| out_err | output | 1 | Result rejected because a lane sits at a rail |
| out_clr_req | output | 1 | Request to overwrite the stored word |
| out_clr_word | output | 32 | Refill pattern for the stored word |

## Verification
The bench builds the block with its default parameters: four 8-bit lanes, rail code 0x7F, an OFDM offset of 32 folded into 6 bits, and a boost of 13. With these values, lanes of 0xFF are legal and push the CCK mean to its 8-bit ceiling of 255. OFDM values can land just below, on and just above the boost threshold, so both sides of the clamp are exercised. A rail lane whose OFDM remap would look ordinary shows that screening works on raw samples.

// File: rtl/txpwr_avg_pkg.sv
package txpwr_avg_pkg;

   typedef enum logic {
      SRC_CCK  = 1'b0,
      SRC_OFDM = 1'b1
   } src_mode_e;

   // Replicate one lane code across all lanes of a word.
   function automatic logic [63:0] lane_fill(input int unsigned lanes,
                                             input int unsigned lane_w,
                                             input logic [63:0] code);
      logic [63:0] acc;
      acc = '0;
      for (int i = 0; i < lanes; i++) begin
         acc = acc | (code << (i * lane_w));
      end
      return acc;
   endfunction

endpackage

// File: rtl/txpwr_lane_cond.sv
module txpwr_lane_cond #(
   parameter int unsigned SAMPLE_W   = 8,
   parameter int unsigned RAIL_CODE  = 8'h7F,
   parameter int unsigned REMAP_OFS  = 32,
   parameter int unsigned REMAP_BITS = 6
) (
   input  logic [SAMPLE_W-1:0] lane_raw,
   input  logic                mode_ofdm,
   output logic                lane_bad,
   output logic [SAMPLE_W-1:0] lane_val
);
   localparam logic [SAMPLE_W-1:0] RAIL_V = SAMPLE_W'(RAIL_CODE);
   localparam logic [SAMPLE_W:0]   OFS_V  = (SAMPLE_W + 1)'(REMAP_OFS);

   logic [SAMPLE_W:0]   shifted;
   logic [SAMPLE_W-1:0] folded;

   // Screening always looks at the raw reading.
   assign lane_bad = (lane_raw == '0) || (lane_raw == RAIL_V);
   assign shifted  = {1'b0, lane_raw} + OFS_V;

   generate
      if (REMAP_BITS < SAMPLE_W) begin : g_fold_narrow
         assign folded = {{(SAMPLE_W - REMAP_BITS){1'b0}}, shifted[REMAP_BITS-1:0]};
      end else begin : g_fold_full
         assign folded = shifted[SAMPLE_W-1:0];
      end
   endgenerate

   assign lane_val = mode_ofdm ? folded : lane_raw;

endmodule

// File: rtl/txpwr_mean.sv
module txpwr_mean #(
   parameter int unsigned LANES    = 4,
   parameter int unsigned SAMPLE_W = 8
) (
   input  logic [LANES*SAMPLE_W-1:0] lanes_flat,
   output logic [SAMPLE_W-1:0]       mean
);
   localparam int unsigned SHIFT = $clog2(LANES);
   localparam int unsigned SUM_W = SAMPLE_W + SHIFT + 1;
   localparam logic [SUM_W-1:0] HALF = SUM_W'(LANES / 2);

   logic [SUM_W-1:0] acc;
   logic [SUM_W-1:0] scaled;

   always_comb begin
      acc = HALF;
      for (int i = 0; i < LANES; i++) begin
         acc = acc + SUM_W'(lanes_flat[i*SAMPLE_W +: SAMPLE_W]);
      end
   end

   assign scaled = acc >> SHIFT;
   assign mean   = scaled[SAMPLE_W-1:0];

endmodule

// File: rtl/txpwr_boost_adj.sv
module txpwr_boost_adj #(
   parameter int unsigned AVG_W = 8,
   parameter int unsigned BOOST = 13
) (
   input  logic [AVG_W-1:0] avg_in,
   input  logic             adj_en,
   output logic [AVG_W-1:0] avg_out
);
   generate
      if (BOOST == 0) begin : g_no_boost
         assign avg_out = avg_in;
      end else begin : g_boost
         localparam logic [AVG_W-1:0] BOOST_V = AVG_W'(BOOST);
         logic below;
         assign below   = avg_in < BOOST_V;
         assign avg_out = !adj_en ? avg_in :
                          below   ? '0     : (avg_in - BOOST_V);
      end
   endgenerate

endmodule

// File: rtl/txpwr_sample_avg.sv
module txpwr_sample_avg #(
   parameter int unsigned LANES      = 4,
   parameter int unsigned SAMPLE_W   = 8,
   parameter int unsigned RAIL_CODE  = 8'h7F,
   parameter int unsigned REMAP_OFS  = 32,
   parameter int unsigned REMAP_BITS = 6,
   parameter int unsigned BOOST      = 13,
   localparam int unsigned WORD_W    = LANES * SAMPLE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_ofdm,
   input  logic              in_boost_en,
   output logic              out_done,
   output logic [SAMPLE_W-1:0] out_avg,
   output logic              out_err,
   output logic              out_clr_req,
   output logic [WORD_W-1:0] out_clr_word
);
   import txpwr_avg_pkg::*;

   localparam logic [WORD_W-1:0] FILL_V =
      WORD_W'(lane_fill(LANES, SAMPLE_W, 64'(RAIL_CODE)));

   initial begin : p_param_chk
      assert (LANES >= 2 && (LANES & (LANES - 1)) == 0)
         else $fatal(1, "LANES must be a power of two of at least 2");
      assert (SAMPLE_W >= 2 && WORD_W <= 64)
         else $fatal(1, "lane width out of range");
      assert (RAIL_CODE > 0 && RAIL_CODE < (1 << SAMPLE_W))
         else $fatal(1, "rail code must fit a lane and be nonzero");
      assert (REMAP_BITS >= 1 && REMAP_BITS <= SAMPLE_W)
         else $fatal(1, "remap width must not exceed the lane width");
      assert (BOOST < (1 << SAMPLE_W))
         else $fatal(1, "boost must fit the average width");
   end

   src_mode_e                mode;
   logic [LANES-1:0]         bad_vec;
   logic [WORD_W-1:0]        cond_flat;
   logic [SAMPLE_W-1:0]      mean_raw;
   logic [SAMPLE_W-1:0]      mean_adj;
   logic                     any_bad;

   assign mode = in_ofdm ? SRC_OFDM : SRC_CCK;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         txpwr_lane_cond #(
            .SAMPLE_W  (SAMPLE_W),
            .RAIL_CODE (RAIL_CODE),
            .REMAP_OFS (REMAP_OFS),
            .REMAP_BITS(REMAP_BITS)
         ) u_cond (
            .lane_raw (in_word[g*SAMPLE_W +: SAMPLE_W]),
            .mode_ofdm(mode == SRC_OFDM),
            .lane_bad (bad_vec[g]),
            .lane_val (cond_flat[g*SAMPLE_W +: SAMPLE_W])
         );
      end
   endgenerate

   assign any_bad = |bad_vec;

   txpwr_mean #(
      .LANES   (LANES),
      .SAMPLE_W(SAMPLE_W)
   ) u_mean (
      .lanes_flat(cond_flat),
      .mean      (mean_raw)
   );

   txpwr_boost_adj #(
      .AVG_W(SAMPLE_W),
      .BOOST(BOOST)
   ) u_boost (
      .avg_in (mean_raw),
      .adj_en ((mode == SRC_OFDM) && in_boost_en),
      .avg_out(mean_adj)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_done     <= 1'b0;
         out_err      <= 1'b0;
         out_avg      <= '0;
         out_clr_req  <= 1'b0;
         out_clr_word <= '0;
      end else if (in_valid) begin
         out_done     <= 1'b1;
         out_err      <= any_bad;
         out_avg      <= any_bad ? '0 : mean_adj;
         out_clr_req  <= !any_bad;
         out_clr_word <= any_bad ? '0 : FILL_V;
      end else begin
         out_done     <= 1'b0;
         out_clr_req  <= 1'b0;
         out_clr_word <= '0;
      end
   end

endmodule

// File: rtl/txpwr_sample_avg_chk.sv
module txpwr_sample_avg_chk #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned SAMPLE_W  = 8,
   parameter int unsigned RAIL_CODE = 8'h7F,
   localparam int unsigned WORD_W   = LANES * SAMPLE_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [WORD_W-1:0]   in_word,
   input logic                out_done,
   input logic [SAMPLE_W-1:0] out_avg,
   input logic                out_err,
   input logic                out_clr_req,
   input logic [WORD_W-1:0]   out_clr_word
);
   localparam logic [SAMPLE_W-1:0] RAIL_V = SAMPLE_W'(RAIL_CODE);

   logic lane0_rail;
   assign lane0_rail = (in_word[SAMPLE_W-1:0] == '0) || (in_word[SAMPLE_W-1:0] == RAIL_V);

   AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_done) else $error("done missing after strobe"); // R7
   AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_done) else $error("done without strobe"); // R7
   AST_RAIL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane0_rail) |=> (out_err && !out_clr_req)) else $error("rail lane accepted"); // R1
   AST_CLR_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      out_clr_req |-> (out_done && !out_err)) else $error("clear request on bad result"); // R2
   AST_CLR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      out_clr_req |-> ($countones(out_clr_word) == LANES * $countones(RAIL_V))) else $error("refill pattern wrong"); // R2
   AST_ERR_ZERO_AVG: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_avg == '0)) else $error("error with nonzero average"); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_avg) && $stable(out_err))) else $error("result changed while idle"); // R10

endmodule

bind txpwr_sample_avg txpwr_sample_avg_chk #(
   .LANES    (LANES),
   .SAMPLE_W (SAMPLE_W),
   .RAIL_CODE(RAIL_CODE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_word     (in_word),
   .out_done    (out_done),
   .out_avg     (out_avg),
   .out_err     (out_err),
   .out_clr_req (out_clr_req),
   .out_clr_word(out_clr_word)
);

// File: tb/txpwr_sample_avg_tb.sv
module txpwr_sample_avg_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        in_ofdm = 1'b0;
   logic        in_boost_en = 1'b0;
   logic        out_done;
   logic [7:0]  out_avg;
   logic        out_err;
   logic        out_clr_req;
   logic [31:0] out_clr_word;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   localparam logic [31:0] FILL = 32'h7F7F7F7F;

   always #4 clk = ~clk;

   txpwr_sample_avg u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_word     (in_word),
      .in_ofdm     (in_ofdm),
      .in_boost_en (in_boost_en),
      .out_done    (out_done),
      .out_avg     (out_avg),
      .out_err     (out_err),
      .out_clr_req (out_clr_req),
      .out_clr_word(out_clr_word)
   );

   // {word, ofdm, boost, exp_err, exp_avg}
   localparam int NV = 20;
   localparam logic [42:0] VEC [NV] = '{
      {32'h10203040, 1'b0, 1'b0, 1'b0, 8'd40},
      {32'h01010101, 1'b0, 1'b0, 1'b0, 8'd1},
      {32'h01010202, 1'b0, 1'b0, 1'b0, 8'd2},
      {32'h7E7E7E7E, 1'b0, 1'b0, 1'b0, 8'd126},
      {32'hFFFFFFFF, 1'b0, 1'b0, 1'b0, 8'd255},
      {32'h80808080, 1'b0, 1'b0, 1'b0, 8'd128},
      {32'h10203040, 1'b0, 1'b1, 1'b0, 8'd40},
      {32'h01010101, 1'b0, 1'b1, 1'b0, 8'd1},
      {32'h10203040, 1'b1, 1'b0, 1'b0, 8'd24},
      {32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 8'd31},
      {32'h10203040, 1'b1, 1'b1, 1'b0, 8'd11},
      {32'h20202020, 1'b1, 1'b1, 1'b0, 8'd0},
      {32'h2D2D2D2D, 1'b1, 1'b1, 1'b0, 8'd0},
      {32'h2E2E2E2E, 1'b1, 1'b1, 1'b0, 8'd1},
      {32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 8'd18},
      {32'h10200040, 1'b0, 1'b0, 1'b1, 8'd0},
      {32'h7F101010, 1'b0, 1'b0, 1'b1, 8'd0},
      {32'h1010107F, 1'b0, 1'b1, 1'b1, 8'd0},
      {32'h10107F10, 1'b1, 1'b0, 1'b1, 8'd0},
      {32'h00000000, 1'b1, 1'b1, 1'b1, 8'd0}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic ofdm, input logic boost, input logic err);
      if (err)               return "R1";
      if (ofdm && boost)     return "R5";
      if (ofdm)              return "R4";
      if (boost)             return "R6";
      return "R3";
   endfunction

   // Strobe one word; returns at the negedge after the capturing posedge.
   task automatic strobe(input logic [31:0] w, input logic ofdm, input logic boost);
      @(negedge clk);
      in_word     = w;
      in_ofdm     = ofdm;
      in_boost_en = boost;
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid    = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog: actual %0d cycles expected below 20000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // Reset state
      check("R8", "done after reset", {31'b0, out_done}, 32'd0);
      check("R8", "err after reset", {31'b0, out_err}, 32'd0);
      check("R8", "avg after reset", {24'b0, out_avg}, 32'd0);
      check("R8", "clr after reset", {31'b0, out_clr_req}, 32'd0);
      check("R8", "clr word after reset", out_clr_word, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7", "no done while idle", {31'b0, out_done}, 32'd0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [31:0] w;
         logic        ofd, bst, xerr;
         logic [7:0]  xavg;
         string       t;
         {w, ofd, bst, xerr, xavg} = VEC[i];
         t = tag_of(ofd, bst, xerr);
         strobe(w, ofd, bst);
         check("R7", "done pulse", {31'b0, out_done}, 32'd1);
         check(t, "average", {24'b0, out_avg}, {24'b0, xavg});
         check(xerr ? "R1" : t, "error flag", {31'b0, out_err}, {31'b0, xerr});
         check("R2", "clear request", {31'b0, out_clr_req}, {31'b0, !xerr});
         check("R2", "clear word", out_clr_word, xerr ? 32'd0 : FILL);
         if (xerr) check("R9", "avg zero on error", {24'b0, out_avg}, 32'd0);
      end

      // Hold while idle, other inputs moving
      strobe(32'h10203040, 1'b0, 1'b0);
      in_word = 32'h00000000; in_ofdm = 1'b1; in_boost_en = 1'b1;
      @(negedge clk);
      check("R7", "done single cycle", {31'b0, out_done}, 32'd0);
      check("R2", "clear single cycle", {31'b0, out_clr_req}, 32'd0);
      check("R2", "clear word drops", out_clr_word, 32'd0);
      repeat (3) @(negedge clk);
      check("R10", "avg held", {24'b0, out_avg}, 32'd40);
      check("R10", "err held", {31'b0, out_err}, 32'd0);

      // Error result held while idle
      strobe(32'h7F7F7F7F, 1'b0, 1'b0);
      in_word = 32'h10101010;
      repeat (2) @(negedge clk);
      check("R10", "err held", {31'b0, out_err}, 32'd1);
      check("R9", "avg held at zero", {24'b0, out_avg}, 32'd0);

      // Back-to-back strobes
      @(negedge clk);
      in_valid = 1'b1; in_word = 32'h10203040; in_ofdm = 1'b0; in_boost_en = 1'b0;
      @(negedge clk);
      check("R7", "first of pair done", {31'b0, out_done}, 32'd1);
      check("R3", "first of pair avg", {24'b0, out_avg}, 32'd40);
      in_word = 32'h10203040; in_ofdm = 1'b1; in_boost_en = 1'b1;
      @(negedge clk);
      check("R7", "second of pair done", {31'b0, out_done}, 32'd1);
      check("R5", "second of pair avg", {24'b0, out_avg}, 32'd11);
      in_word = 32'h00101010;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1", "third of run err", {31'b0, out_err}, 32'd1);
      check("R2", "third of run no clear", {31'b0, out_clr_req}, 32'd0);
      @(negedge clk);
      check("R7", "run ends", {31'b0, out_done}, 32'd0);

      // Reset mid-run
      strobe(32'h7E7E7E7E, 1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R8", "avg cleared by reset", {24'b0, out_avg}, 32'd0);
      check("R8", "done cleared by reset", {31'b0, out_done}, 32'd0);
      check("R8", "clr cleared by reset", {31'b0, out_clr_req}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      finish_run();
   end

endmodule